// File: doc/BRIEF.md
# Bit-Serial Distributed-Arithmetic FIR Filter

This block is a 16-tap finite impulse response filter. Its coefficients are fixed when the design is built. Samples and coefficients are 8-bit two's-complement values. The block computes no products. It holds the sample history as bits and reads one bit of every tap per clock, least significant bit first. Each group of four taps forms a 4-bit index into its own 16-entry table. Each table entry is the sum of the coefficients whose index bit is set. Two levels of adders join the four table outputs. A shifting accumulator weights each bit's sum and adds it in, and it subtracts the sum on the sign-bit clock. One output therefore takes eight clocks.

The newest sample sits in a parallel-load shift register. Each older sample is held in an 8-entry, 1-bit-wide RAM, one bit per address. All RAMs share one 3-bit bit counter. On every clock of a filter cycle, each RAM's bit is read for the tables and is also written to the same address of the next RAM. The first RAM takes the bit that leaves the newest-sample register. When the eight clocks end, the whole history has moved one tap and the oldest sample is gone.

A controller with two states, IDLE and RUN, sequences the block. IDLE->RUN is taken when a sample arrives while idle. RUN->RUN (restart) is taken at the last bit when a new or held sample is ready. RUN->IDLE is taken at the last bit when no sample is ready. A sample that arrives during RUN goes into a one-entry holding register and starts the next cycle.

Top module: `dafir_filter`

## Requirements
- R1: After reset, out_valid is 0, out_data is 0, and every history tap reads as zero. The first output after a reset is therefore c0 times the first sample.
- R2: Each accepted sample x[n] produces one result, sum over k=0..15 of c_k * x[n-k]. It is a 20-bit two's-complement value on out_data. Coefficient c_k sits at COEFS bits [8k+7:8k].
- R3: out_valid is a one-clock pulse. It rises at the eighth rising edge after the edge that accepts the sample.
- R4: Tap k uses the sample accepted k samples earlier. A sample is dropped after it has been used at tap 15.
- R5: Bit 7 of a sample has weight -128, so the sign bit is subtracted.
- R6: A sample presented while a cycle is running is held. It is accepted at the edge that ends that cycle, and its result follows the previous one by eight clocks.
- R7: When more than one sample arrives during one cycle, only the last one is kept. The earlier ones never enter the history.
- R8: A sample presented at the last bit edge of a cycle starts the next cycle at once. Results then come out every eight clocks.
- R9: Idle clocks between samples leave the history unchanged.
- R10: out_data holds its value between out_valid pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A sample is present on in_data |
| in_data | input | 8 | Signed input sample |
| out_valid | output | 1 | One-clock pulse marking a new result |
| out_data | output | 20 | Signed filter result |

## Verification
The hardest cases to reach are those where an arrival lands inside a running cycle. These are a sample held mid-cycle, a held sample that a later one replaces, and an arrival on exactly the last bit edge. In each case the correct history order depends on the clock offset of in_valid relative to the accepting edge. The stimulus drives in_valid on falling edges counted from the accepting edge: at offsets 3, 2 and 4, and 8. It then checks that the results come out eight clocks apart. It also checks that the next result is consistent with a history that never held the discarded sample. An impulse followed by sixteen zeros walks a single value through every RAM stage.

// File: rtl/dafir_pkg.sv
package dafir_pkg;

    // Controller states of the bit-serial filter.
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } dafir_state_e;

endpackage

// File: rtl/dafir_bit_ram.sv
// One history word stored as DEPTH single-bit entries, one per address.
// Read is combinational, write is synchronous, so a read-then-pass chain
// sees the old contents in the same clock it overwrites the neighbour.
module dafir_bit_ram #(
    parameter int DEPTH = 8,
    parameter int AW    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic          wbit,
    output logic          rbit
);

    logic [DEPTH-1:0] mem_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_q <= '0;
        end else if (we) begin
            mem_q[addr] <= wbit;
        end
    end

    assign rbit = mem_q[addr];

endmodule

// File: rtl/dafir_load_shift.sv
// Newest-sample register: parallel load, then one bit out per clock, LSB first.
module dafir_load_shift #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] din,
    input  logic          shift,
    output logic          sbit
);

    logic [DW-1:0] word_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (load) begin
            word_q <= din;
        end else if (shift) begin
            word_q <= {1'b0, word_q[DW-1:1]};
        end
    end

    assign sbit = word_q[0];

endmodule

// File: rtl/dafir_coef_table.sv
// Sixteen-entry table for one group of four taps. Entry a holds the sum of
// the coefficients whose bit in a is set; the contents are computed from the
// coefficient parameter at elaboration.
module dafir_coef_table #(
    parameter int              CW     = 8,
    parameter int              TW     = CW + 2,
    parameter logic [4*CW-1:0] GCOEFS = '0
) (
    input  logic [3:0]           sel,
    output logic signed [TW-1:0] sum
);

    function automatic logic signed [TW-1:0] entry_of(input logic [3:0] a);
        logic signed [TW-1:0] acc;
        logic signed [CW-1:0] c;
        acc = '0;
        for (int j = 0; j < 4; j++) begin
            c = GCOEFS[j*CW +: CW];
            if (a[j]) acc = acc + TW'(c);
        end
        return acc;
    endfunction

    logic signed [TW-1:0] rom [16];

    for (genvar a = 0; a < 16; a++) begin : g_entry
        assign rom[a] = entry_of(4'(a));
    end

    assign sum = rom[sel];

endmodule

// File: rtl/dafir_filter.sv
// Bit-serial distributed-arithmetic FIR filter, 16 taps in four groups.
module dafir_filter
    import dafir_pkg::*;
#(
    parameter int                DW    = 8,
    parameter int                CW    = 8,
    parameter int                NTAP  = 16,
    parameter int                OW    = CW + DW + 4,
    parameter logic [NTAP*CW-1:0] COEFS =
        128'h029C2DFF0CB36300_01C040FD057F8011
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [DW-1:0] in_data,
    output logic          out_valid,
    output logic [OW-1:0] out_data
);

    localparam int GRP   = 4;
    localparam int NGRP  = NTAP / GRP;
    localparam int NPAIR = NGRP / 2;
    localparam int AW    = $clog2(DW);
    localparam int TW    = CW + 2;      // table entry width
    localparam int L1W   = TW + 1;      // first adder level
    localparam int L2W   = TW + 2;      // second adder level
    localparam int TSW   = L2W + 2;     // running accumulator adder
    localparam int HW    = OW - DW;     // upper result bits

    // ------------------------------------------------------------------
    // Controller state
    // ------------------------------------------------------------------
    dafir_state_e  state_q, state_d;
    logic [AW-1:0] bit_q;
    logic          pend_v_q;
    logic [DW-1:0] pend_d_q;

    logic run, last_bit, ready, start;
    logic [DW-1:0] start_data;

    assign run        = (state_q == ST_RUN);
    assign last_bit   = run && (bit_q == AW'(DW - 1));
    assign ready      = in_valid || pend_v_q;
    assign start      = ((state_q == ST_IDLE) && in_valid) || (last_bit && ready);
    assign start_data = in_valid ? in_data : pend_d_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (in_valid) state_d = ST_RUN;
            ST_RUN:  if (last_bit && !ready) state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            bit_q    <= '0;
            pend_v_q <= 1'b0;
            pend_d_q <= '0;
        end else begin
            state_q <= state_d;
            bit_q   <= run ? bit_q + 1'b1 : '0;
            if (start) begin
                pend_v_q <= 1'b0;
            end else if (run && in_valid) begin
                pend_v_q <= 1'b1;
                pend_d_q <= in_data;
            end
        end
    end

    // ------------------------------------------------------------------
    // History: newest word in flip-flops, older words in a RAM chain
    // ------------------------------------------------------------------
    logic            newest_bit;
    logic [NTAP-2:0] ram_rd;
    logic [NTAP-1:0] tap_bit;

    dafir_load_shift #(.DW(DW)) u_newest (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (start),
        .din   (start_data),
        .shift (run),
        .sbit  (newest_bit)
    );

    assign tap_bit = {ram_rd, newest_bit};

    for (genvar k = 0; k < NTAP - 1; k++) begin : g_ram
        dafir_bit_ram #(.DEPTH(DW), .AW(AW)) u_ram (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (run),
            .addr  (bit_q),
            .wbit  (tap_bit[k]),
            .rbit  (ram_rd[k])
        );
    end

    // ------------------------------------------------------------------
    // Tables and two-level adder tree
    // ------------------------------------------------------------------
    logic signed [TW-1:0]  tbl_sum [NGRP];
    logic signed [L1W-1:0] lvl1    [NPAIR];
    logic signed [L2W-1:0] lvl2;

    for (genvar g = 0; g < NGRP; g++) begin : g_tbl
        dafir_coef_table #(
            .CW     (CW),
            .TW     (TW),
            .GCOEFS (COEFS[g*GRP*CW +: GRP*CW])
        ) u_tbl (
            .sel (tap_bit[g*GRP +: GRP]),
            .sum (tbl_sum[g])
        );
    end

    for (genvar p = 0; p < NPAIR; p++) begin : g_lvl1
        assign lvl1[p] = L1W'(tbl_sum[2*p]) + L1W'(tbl_sum[2*p+1]);
    end

    assign lvl2 = L2W'(lvl1[0]) + L2W'(lvl1[1]);

    // ------------------------------------------------------------------
    // Shifting accumulator: low bits retire one per clock
    // ------------------------------------------------------------------
    logic signed [TSW-1:0] hi_q, base, term, tsum, hi_next;
    logic [DW-1:0]         lo_q, lo_next;

    always_comb begin
        base    = (bit_q == '0) ? '0 : hi_q;
        term    = last_bit ? -TSW'(lvl2) : TSW'(lvl2);
        tsum    = base + term;
        hi_next = tsum >>> 1;
        lo_next = {tsum[0], lo_q[DW-1:1]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q      <= '0;
            lo_q      <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= last_bit;
            if (run) begin
                hi_q <= hi_next;
                lo_q <= lo_next;
            end
            if (last_bit) begin
                out_data <= {hi_next[HW-1:0], lo_next};
            end
        end
    end

endmodule

// File: rtl/dafir_filter_chk.sv
module dafir_filter_chk
    import dafir_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 3,
    parameter int OW = 20
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          out_valid,
    input logic [OW-1:0] out_data,
    input dafir_state_e  state,
    input logic [AW-1:0] bit_idx,
    input logic          pend_v
);

    // R3: one-clock result pulse
    p_single_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R3: a result appears only right after the last bit clock
    p_after_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(state == ST_RUN && bit_idx == AW'(DW - 1)));

    // R10: result is held between pulses
    p_hold_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_data));

    // R6: mid-cycle arrival is captured in the holding register
    p_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && bit_idx != AW'(DW - 1) && in_valid) |=> pend_v);

    // R8: a ready sample restarts the cycle at bit 0
    p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && bit_idx == AW'(DW - 1) && (in_valid || pend_v))
        |=> (state == ST_RUN && bit_idx == '0 && !pend_v));

    // R9: idle keeps the bit counter parked and nothing pending
    p_idle_park_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (bit_idx == '0 && !pend_v));

endmodule

bind dafir_filter dafir_filter_chk #(.DW(DW), .AW(AW), .OW(OW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_data  (out_data),
    .state     (state_q),
    .bit_idx   (bit_q),
    .pend_v    (pend_v_q)
);

// File: tb/dafir_filter_bench.sv
module dafir_filter_bench;

    localparam int CLK_PERIOD = 10;
    localparam logic [127:0] BCOEF = 128'h029C2DFF0CB36300_01C040FD057F8011;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        out_valid;
    logic [19:0] out_data;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    int coef [16];
    int hist [16];

    always #(CLK_PERIOD / 2) clk = ~clk;

    dafir_filter #(.COEFS(BCOEF)) u_dafir_filter (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    function automatic int sdata();
        logic signed [19:0] s;
        s = out_data;
        return int'(s);
    endfunction

    function int push_eval(int x);
        int acc;
        for (int k = 15; k > 0; k--) hist[k] = hist[k-1];
        hist[0] = x;
        acc = 0;
        for (int k = 0; k < 16; k++) acc += coef[k] * hist[k];
        return acc;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_model();
        for (int k = 0; k < 16; k++) hist[k] = 0;
    endtask

    // Send one sample while idle, check pulse timing, value and hold.
    task automatic run_sample(input int x, input string req);
        int e;
        int held;
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = 8'(x);
        e = push_eval(x);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (7) @(negedge clk);
        chk(out_valid == 1'b0, "R3", int'(out_valid), 0);
        @(negedge clk);
        chk(out_valid == 1'b1, "R3", int'(out_valid), 1);
        chk(sdata() == e, req, sdata(), e);
        held = sdata();
        @(negedge clk);
        chk(out_valid == 1'b0 && sdata() == held, "R10", sdata(), held);
    endtask

    task automatic t_reset_state();
        chk(out_valid == 1'b0, "R1", int'(out_valid), 0);
        chk(out_data == '0, "R1", sdata(), 0);
    endtask

    task automatic t_impulse();
        // R1 and R4: impulse walks through every tap, then leaves
        run_sample(1, "R1");
        for (int i = 1; i < 16; i++) run_sample(0, "R4");
        run_sample(0, "R4");
    endtask

    task automatic t_extremes();
        // R5: sign bit weighted -128
        for (int i = 0; i < 16; i++) run_sample(-128, "R5");
        for (int i = 0; i < 16; i++) run_sample(127, "R2");
        run_sample(-1, "R5");
    endtask

    task automatic t_pattern();
        int v;
        v = 37;
        for (int i = 0; i < 20; i++) begin
            v = (v * 29 + 11) % 256;
            run_sample(v - 128, "R2");
        end
    endtask

    task automatic t_back_to_back();
        int ea, eb;
        @(negedge clk);                 // N0
        in_valid = 1'b1; in_data = 8'(55); ea = push_eval(55);
        @(negedge clk);                 // N1
        in_valid = 1'b0;
        repeat (7) @(negedge clk);      // N8: present at the last bit edge
        in_valid = 1'b1; in_data = 8'(-90); eb = push_eval(-90);
        @(negedge clk);                 // N9
        in_valid = 1'b0;
        chk(out_valid == 1'b1 && sdata() == ea, "R8", sdata(), ea);
        repeat (7) @(negedge clk);      // N16
        chk(out_valid == 1'b0, "R8", int'(out_valid), 0);
        @(negedge clk);                 // N17
        chk(out_valid == 1'b1 && sdata() == eb, "R8", sdata(), eb);
        @(negedge clk);
    endtask

    task automatic t_held();
        int ea, eb;
        @(negedge clk);                 // N0
        in_valid = 1'b1; in_data = 8'(-7); ea = push_eval(-7);
        @(negedge clk);                 // N1
        in_valid = 1'b0;
        repeat (2) @(negedge clk);      // N3: mid-cycle
        in_valid = 1'b1; in_data = 8'(100); eb = push_eval(100);
        @(negedge clk);                 // N4
        in_valid = 1'b0;
        repeat (5) @(negedge clk);      // N9
        chk(out_valid == 1'b1 && sdata() == ea, "R6", sdata(), ea);
        repeat (7) @(negedge clk);      // N16
        chk(out_valid == 1'b0, "R6", int'(out_valid), 0);
        @(negedge clk);                 // N17
        chk(out_valid == 1'b1 && sdata() == eb, "R6", sdata(), eb);
        @(negedge clk);
    endtask

    task automatic t_replace();
        int ea, ec;
        @(negedge clk);                 // N0
        in_valid = 1'b1; in_data = 8'(12); ea = push_eval(12);
        @(negedge clk);                 // N1
        in_valid = 1'b0;
        @(negedge clk);                 // N2: discarded sample
        in_valid = 1'b1; in_data = 8'(-128);
        @(negedge clk);                 // N3
        in_valid = 1'b0;
        @(negedge clk);                 // N4: replacement
        in_valid = 1'b1; in_data = 8'(64); ec = push_eval(64);
        @(negedge clk);                 // N5
        in_valid = 1'b0;
        repeat (4) @(negedge clk);      // N9
        chk(out_valid == 1'b1 && sdata() == ea, "R7", sdata(), ea);
        repeat (8) @(negedge clk);      // N17
        chk(out_valid == 1'b1 && sdata() == ec, "R7", sdata(), ec);
        repeat (9) @(negedge clk);      // N26: no third result
        chk(out_valid == 1'b0 && sdata() == ec, "R7", sdata(), ec);
        run_sample(3, "R7");
    endtask

    task automatic t_idle_gap();
        repeat (37) @(negedge clk);
        run_sample(-45, "R9");
        repeat (5) @(negedge clk);
        run_sample(77, "R9");
    endtask

    task automatic t_reset_mid();
        @(negedge clk);
        in_valid = 1'b1; in_data = 8'(90);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        chk(out_valid == 1'b0 && out_data == '0, "R1", sdata(), 0);
        clear_model();
        run_sample(5, "R1");
        run_sample(-3, "R1");
    endtask

    initial begin
        for (int k = 0; k < 16; k++) coef[k] = int'($signed(BCOEF[k*8 +: 8]));
        clear_model();
        repeat (3) @(negedge clk);
        t_reset_state();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_impulse();
        t_extremes();
        t_pattern();
        t_back_to_back();
        t_held();
        t_replace();
        t_idle_gap();
        t_reset_mid();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule